// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the host-facing register set of a four-channel DMA controller. A host reaches it over an 8-bit I/O bus with a 4-bit register offset, a chip select and separate read and write strobes. Each channel has a 16-bit transfer address and a 16-bit transfer count. Both are held as a base copy and a current copy, and each is reached through a single byte-wide port. One shared byte-pointer flip-flop steps every such port through its low byte and then its high byte.

Around the per-channel words sit a mode byte for each channel, a four-bit channel mask, a command byte, a software request register, terminal-count and pending-request status, and a temporary byte. There are also write-only strobes that reset the byte pointer, perform a master clear, unmask every channel, or load all mask bits at once.

A separate channel engine reads the programmed values, masks and autoinit flags from the output ports. It writes current address and count values back so the host can read progress. The engine also reports terminal counts, hardware requests and temporary-register data.

Top module: `chan_prog_regs`

## Requirements
- R1: After reset all four mask bits are set, the command byte is 0x00, a status read returns 0x00, and every base and current address and count is 0x0000.
- R2: A write to offset 2n (n = 0..3) loads one byte of channel n's address into both the base and the current copy. With the byte pointer at low the byte goes to bits [7:0], and with it at high the byte goes to bits [15:8]. Reading offset 2n returns the selected byte of the current address.
- R3: Offset 2n+1 behaves the same way for channel n's transfer count, and a read of it returns the selected byte of the current count.
- R4: The byte pointer is shared by all eight address and count ports and flips after every read or write to any of them. A write of any value to offset 0xC forces it to low.
- R5: A write to offset 0xA sets the mask bit of the channel named in data bits [1:0] when data bit 2 is 1, and clears that mask bit when data bit 2 is 0. Other mask bits are unchanged.
- R6: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the four mask bits from data bits [3:0].
- R7: A write to offset 0xB stores the whole byte as the mode of the channel named in data bits [1:0]. That channel's autoinit output equals bit 4 of the stored byte. Bits [3:2] (01 I/O-to-memory, 10 memory-to-I/O) and bits [7:6] (01 single, 11 cascade) are passed to the engine unchanged.
- R8: A write to offset 0x8 loads the command byte.
- R9: A read of offset 0x8 returns the terminal-count flags in bits [3:0] and the pending-request flags in bits [7:4]. A pending request is a hardware request or a software request. An engine terminal-count pulse sets its flag. A status read clears the flags, but a pulse arriving in the same cycle as the read survives it.
- R10: A write to offset 0x9 sets the software request of the channel named in data bits [1:0] when data bit 2 is 1, and clears it when data bit 2 is 0.
- R11: A write to offset 0xD clears the command, the terminal-count flags, the software requests and the temporary byte, returns the byte pointer to low, and sets all mask bits. Addresses, counts and modes are kept.
- R12: A read of offset 0xD returns the temporary byte last captured from the engine.
- R13: An engine write-back strobe for channel n replaces its current address and count and leaves the base copies alone. A completed transfer written back as 0xFFFF reads back as 0xFF, 0xFF. A host write in the same cycle takes precedence for the byte it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (takes precedence over read) |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| eng_base_addr | output | 64 | Base address of each channel, 16 bits per channel |
| eng_base_cnt | output | 64 | Base count of each channel |
| eng_cur_addr | output | 64 | Current address of each channel |
| eng_cur_cnt | output | 64 | Current count of each channel |
| eng_mode | output | 32 | Mode byte of each channel |
| eng_autoinit | output | 4 | Autoinit flag of each channel |
| eng_mask | output | 4 | Channel mask bits |
| eng_cmd | output | 8 | Command byte |
| eng_sreq | output | 4 | Software request per channel |
| eng_wb_we | input | 4 | Per-channel write-back strobe for current address and count |
| eng_wb_addr | input | 64 | Written-back current addresses |
| eng_wb_cnt | input | 64 | Written-back current counts |
| eng_tc | input | 4 | Terminal-count pulse per channel |
| eng_hreq | input | 4 | Hardware request level per channel |
| eng_temp_we | input | 1 | Temporary byte capture strobe |
| eng_temp_data | input | 8 | Temporary byte value |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit data path. That gives 16-bit words split across two bus accesses and a status byte split evenly between terminal-count and request halves. These values make every offset of the 4-bit map reachable. They also let one test interleave address and count ports on the shared pointer. The same settings cover the collisions that matter: a terminal-count pulse during a status read, and master clear with the pointer left at high.

// File: rtl/chan_prog_pkg.sv
package chan_prog_pkg;
    // Register offsets above the per-channel data ports
    localparam logic [3:0] OFF_CMD    = 4'h8;  // command write / status read
    localparam logic [3:0] OFF_SREQ   = 4'h9;  // software request
    localparam logic [3:0] OFF_MSK1   = 4'hA;  // single channel mask
    localparam logic [3:0] OFF_MODE   = 4'hB;  // channel mode
    localparam logic [3:0] OFF_PTRCLR = 4'hC;  // byte pointer to low
    localparam logic [3:0] OFF_MCLR   = 4'hD;  // master clear / temp read
    localparam logic [3:0] OFF_MSKCLR = 4'hE;  // unmask all
    localparam logic [3:0] OFF_MSKALL = 4'hF;  // load all masks

    localparam int MODE_AUTOINIT_BIT = 4;
    localparam int CTL_SET_BIT       = 2;

    function automatic logic [15:0] put_byte(input logic [15:0] word,
                                             input logic        hi,
                                             input logic [7:0]  b);
        put_byte = hi ? {b, word[7:0]} : {word[15:8], b};
    endfunction
endpackage

// File: rtl/cp_chan_slot.sv
module cp_chan_slot #(
    parameter int DW = 8,
    localparam int WW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    input  logic          wb_we,
    input  logic [WW-1:0] wb_addr,
    input  logic [WW-1:0] wb_cnt,
    output logic [WW-1:0] base_addr,
    output logic [WW-1:0] base_cnt,
    output logic [WW-1:0] cur_addr,
    output logic [WW-1:0] cur_cnt
);
    typedef struct packed {
        logic [WW-1:0] b_addr;
        logic [WW-1:0] b_cnt;
        logic [WW-1:0] c_addr;
        logic [WW-1:0] c_cnt;
    } slot_t;

    slot_t st_d, st_q;

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] w,
                                            input logic hi,
                                            input logic [DW-1:0] b);
        merge = hi ? {b, w[DW-1:0]} : {w[WW-1:DW], b};
    endfunction

    always_comb begin
        st_d = st_q;
        if (wb_we) begin
            st_d.c_addr = wb_addr;
            st_d.c_cnt  = wb_cnt;
        end
        // host write lands after the engine write-back, so it wins its byte
        if (wr_addr) begin
            st_d.b_addr = merge(st_q.b_addr, hi_sel, wdata);
            st_d.c_addr = merge(st_d.c_addr, hi_sel, wdata);
        end
        if (wr_cnt) begin
            st_d.b_cnt = merge(st_q.b_cnt, hi_sel, wdata);
            st_d.c_cnt = merge(st_d.c_cnt, hi_sel, wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_addr = st_q.b_addr;
    assign base_cnt  = st_q.b_cnt;
    assign cur_addr  = st_q.c_addr;
    assign cur_cnt   = st_q.c_cnt;
endmodule

// File: rtl/cp_ctrl.sv
module cp_ctrl
    import chan_prog_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH),
    localparam int DATA_PORTS = 2 * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [3:0]        off,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    eng_tc,
    input  logic [NCH-1:0]    eng_hreq,
    input  logic              eng_temp_we,
    input  logic [DW-1:0]     eng_temp_data,
    output logic              hi_sel,
    output logic [DW-1:0]     cmd,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    sreq,
    output logic [NCH*DW-1:0] mode,
    output logic [2*NCH-1:0]  status,
    output logic [DW-1:0]     temp
);
    typedef struct packed {
        logic                    ptr;
        logic [DW-1:0]           cmd;
        logic [NCH-1:0]          mask;
        logic [NCH-1:0]          tc;
        logic [NCH-1:0]          sreq;
        logic [DW-1:0]           temp;
        logic [NCH-1:0][DW-1:0]  mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CW-1:0] sel_ch;
    logic          data_port;

    assign sel_ch    = wdata[CW-1:0];
    assign data_port = (32'(off) < DATA_PORTS);

    always_comb begin
        ctl_d = ctl_q;

        if (eng_temp_we) ctl_d.temp = eng_temp_data;

        // status read clears old flags; a pulse this cycle still registers
        if (rd_stb && off == OFF_CMD) ctl_d.tc = eng_tc;
        else                          ctl_d.tc = ctl_q.tc | eng_tc;

        if ((wr_stb || rd_stb) && data_port) ctl_d.ptr = ~ctl_q.ptr;

        if (wr_stb) begin
            case (off)
                OFF_CMD:    ctl_d.cmd = wdata;
                OFF_SREQ:   ctl_d.sreq[sel_ch] = wdata[CTL_SET_BIT];
                OFF_MSK1:   ctl_d.mask[sel_ch] = wdata[CTL_SET_BIT];
                OFF_MODE:   ctl_d.mode[sel_ch] = wdata;
                OFF_PTRCLR: ctl_d.ptr = 1'b0;
                OFF_MCLR: begin
                    ctl_d.cmd  = '0;
                    ctl_d.tc   = '0;
                    ctl_d.sreq = '0;
                    ctl_d.temp = '0;
                    ctl_d.ptr  = 1'b0;
                    ctl_d.mask = '1;
                end
                OFF_MSKCLR: ctl_d.mask = '0;
                OFF_MSKALL: ctl_d.mask = wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hi_sel = ctl_q.ptr;
    assign cmd    = ctl_q.cmd;
    assign mask   = ctl_q.mask;
    assign sreq   = ctl_q.sreq;
    assign mode   = ctl_q.mode;
    assign temp   = ctl_q.temp;
    assign status = {ctl_q.sreq | eng_hreq, ctl_q.tc};
endmodule

// File: rtl/cp_rdmux.sv
module cp_rdmux
    import chan_prog_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int WW = 2 * DW,
    localparam int CW = $clog2(NCH),
    localparam int DATA_PORTS = 2 * NCH
) (
    input  logic [3:0]        off,
    input  logic              hi_sel,
    input  logic [NCH*WW-1:0] cur_addr,
    input  logic [NCH*WW-1:0] cur_cnt,
    input  logic [2*NCH-1:0]  status,
    input  logic [DW-1:0]     temp,
    output logic [DW-1:0]     rdata
);
    logic [CW-1:0] ch;
    logic [WW-1:0] word;

    assign ch = off[CW:1];

    always_comb begin
        word = off[0] ? cur_cnt[ch*WW +: WW] : cur_addr[ch*WW +: WW];
        if (32'(off) < DATA_PORTS)  rdata = hi_sel ? word[WW-1:DW] : word[DW-1:0];
        else if (off == OFF_CMD)    rdata = DW'(status);
        else if (off == OFF_MCLR)   rdata = temp;
        else                        rdata = '0;
    end
endmodule

// File: rtl/chan_prog_regs.sv
module chan_prog_regs
    import chan_prog_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int WW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_off,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH*WW-1:0] eng_base_addr,
    output logic [NCH*WW-1:0] eng_base_cnt,
    output logic [NCH*WW-1:0] eng_cur_addr,
    output logic [NCH*WW-1:0] eng_cur_cnt,
    output logic [NCH*DW-1:0] eng_mode,
    output logic [NCH-1:0]    eng_autoinit,
    output logic [NCH-1:0]    eng_mask,
    output logic [DW-1:0]     eng_cmd,
    output logic [NCH-1:0]    eng_sreq,
    input  logic [NCH-1:0]    eng_wb_we,
    input  logic [NCH*WW-1:0] eng_wb_addr,
    input  logic [NCH*WW-1:0] eng_wb_cnt,
    input  logic [NCH-1:0]    eng_tc,
    input  logic [NCH-1:0]    eng_hreq,
    input  logic              eng_temp_we,
    input  logic [DW-1:0]     eng_temp_data
);
    logic             wr_stb, rd_stb, byte_hi;
    logic [2*NCH-1:0] stat_byte;
    logic [DW-1:0]    temp_byte;

    assign wr_stb = bus_cs && bus_wr;
    assign rd_stb = bus_cs && bus_rd && !bus_wr;

    cp_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .off(bus_off), .wdata(bus_wdata), .eng_tc(eng_tc),
        .eng_hreq(eng_hreq), .eng_temp_we(eng_temp_we),
        .eng_temp_data(eng_temp_data), .hi_sel(byte_hi), .cmd(eng_cmd),
        .mask(eng_mask), .sreq(eng_sreq), .mode(eng_mode),
        .status(stat_byte), .temp(temp_byte)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic wa, wc;
        assign wa = wr_stb && (bus_off == 4'(2 * g));
        assign wc = wr_stb && (bus_off == 4'(2 * g + 1));
        assign eng_autoinit[g] = eng_mode[g*DW + MODE_AUTOINIT_BIT];

        cp_chan_slot #(.DW(DW)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_addr(wa), .wr_cnt(wc),
            .hi_sel(byte_hi), .wdata(bus_wdata), .wb_we(eng_wb_we[g]),
            .wb_addr(eng_wb_addr[g*WW +: WW]), .wb_cnt(eng_wb_cnt[g*WW +: WW]),
            .base_addr(eng_base_addr[g*WW +: WW]),
            .base_cnt(eng_base_cnt[g*WW +: WW]),
            .cur_addr(eng_cur_addr[g*WW +: WW]),
            .cur_cnt(eng_cur_cnt[g*WW +: WW])
        );
    end

    cp_rdmux #(.NCH(NCH), .DW(DW)) u_rdmux (
        .off(bus_off), .hi_sel(byte_hi), .cur_addr(eng_cur_addr),
        .cur_cnt(eng_cur_cnt), .status(stat_byte), .temp(temp_byte),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/chan_prog_chk.sv
module chan_prog_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int WW = 2 * DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [3:0]        bus_off,
    input logic [DW-1:0]     bus_wdata,
    input logic [NCH-1:0]    eng_mask,
    input logic [DW-1:0]     eng_cmd,
    input logic [NCH*WW-1:0] eng_base_addr,
    input logic [NCH-1:0]    eng_tc,
    input logic              byte_hi,
    input logic [2*NCH-1:0]  stat_byte
);
    logic wr_any, acc_data;
    assign wr_any   = bus_cs && bus_wr;
    assign acc_data = bus_cs && (bus_wr || bus_rd) && (32'(bus_off) < 2 * NCH);

    assert_mclr_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_off == 4'hD) |=> (eng_mask == '1 && eng_cmd == '0 && !byte_hi));

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_off == 4'hF) |=> eng_mask == $past(bus_wdata[NCH-1:0]));

    assert_cmd_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_off == 4'h8) |=> eng_cmd == $past(bus_wdata));

    assert_ptr_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_data |=> byte_hi != $past(byte_hi));

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_off == 4'hC) |=> !byte_hi);

    assert_tc_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eng_tc) && !(wr_any && bus_off == 4'hD))
        |=> ((stat_byte[NCH-1:0] & $past(eng_tc)) == $past(eng_tc)));

    assert_base_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && (32'(bus_off) < 2 * NCH)) |=> $stable(eng_base_addr));
endmodule

bind chan_prog_regs chan_prog_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .eng_mask(eng_mask), .eng_cmd(eng_cmd), .eng_base_addr(eng_base_addr),
    .eng_tc(eng_tc), .byte_hi(byte_hi), .stat_byte(stat_byte)
);

// File: tb/sim_chan_prog_regs.sv
module sim_chan_prog_regs;
    localparam int CLK_P = 10;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int WW  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
    logic [3:0] bus_off = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [NCH*WW-1:0] eng_base_addr, eng_base_cnt, eng_cur_addr, eng_cur_cnt;
    logic [NCH*DW-1:0] eng_mode;
    logic [NCH-1:0] eng_autoinit, eng_mask, eng_sreq;
    logic [7:0] eng_cmd;
    logic [NCH-1:0] eng_wb_we = '0, eng_tc = '0, eng_hreq = '0;
    logic [NCH*WW-1:0] eng_wb_addr = '0, eng_wb_cnt = '0;
    logic eng_temp_we = 0;
    logic [7:0] eng_temp_data = '0;

    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    chan_prog_regs #(.NCH(NCH), .DW(DW)) u0 (.*);

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_off = off;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check(eng_mask == 4'hF, "R1 mask", 32'(eng_mask), 32'hF);
        check(eng_cmd == 0, "R1 cmd", 32'(eng_cmd), 0);
        check(eng_base_addr == 0 && eng_cur_cnt == 0, "R1 words",
              eng_base_addr[31:0], 0);
        rd(4'h8, d);
        check(d == 0, "R1 status", 32'(d), 0);
    endtask

    task automatic t_addr;
        logic [7:0] lo, hi;
        wr(4'hC, 8'h00);
        for (int n = 0; n < NCH; n++) begin
            wr(4'(2*n), 8'(8'hA0 + n));
            wr(4'(2*n), 8'(8'h10 + n));
            check(eng_base_addr[n*WW +: WW] == {8'(8'h10 + n), 8'(8'hA0 + n)},
                  "R2 base addr", 32'(eng_base_addr[n*WW +: WW]), 0);
            check(eng_cur_addr[n*WW +: WW] == eng_base_addr[n*WW +: WW],
                  "R2 cur addr", 32'(eng_cur_addr[n*WW +: WW]), 0);
        end
        rd(4'h4, lo); rd(4'h4, hi);
        check({hi, lo} == 16'h12A2, "R2 readback", {16'h0, hi, lo}, 32'h12A2);
    endtask

    task automatic t_cnt;
        logic [7:0] lo, hi;
        wr(4'h3, 8'hEF); wr(4'h3, 8'hBE);
        check(eng_base_cnt[1*WW +: WW] == 16'hBEEF, "R3 base cnt",
              32'(eng_base_cnt[1*WW +: WW]), 32'hBEEF);
        rd(4'h3, lo); rd(4'h3, hi);
        check({hi, lo} == 16'hBEEF, "R3 readback", {16'h0, hi, lo}, 32'hBEEF);
    endtask

    task automatic t_ptr;
        logic [7:0] d;
        wr(4'hC, 8'h5A);
        wr(4'h0, 8'h11);        // pointer now high
        wr(4'h1, 8'h22);        // lands in count high byte
        check(eng_base_cnt[15:8] == 8'h22, "R4 shared ptr",
              32'(eng_base_cnt[15:8]), 32'h22);
        wr(4'h6, 8'h55);        // pointer high again
        wr(4'hC, 8'h00);
        wr(4'h6, 8'h66);        // back to low byte
        check(eng_base_addr[3*WW +: 8] == 8'h66, "R4 ptr clear",
              32'(eng_base_addr[3*WW +: 8]), 32'h66);
        wr(4'hC, 8'h00);
        rd(4'h0, d);
        check(d == 8'h11, "R4 read low", 32'(d), 32'h11);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_mask;
        wr(4'hE, 8'hFF);
        check(eng_mask == 0, "R6 clear all", 32'(eng_mask), 0);
        wr(4'hA, 8'h06);
        check(eng_mask == 4'b0100, "R5 set ch2", 32'(eng_mask), 32'h4);
        wr(4'hA, 8'h07);
        check(eng_mask == 4'b1100, "R5 set ch3", 32'(eng_mask), 32'hC);
        wr(4'hA, 8'h02);
        check(eng_mask == 4'b1000, "R5 clear ch2", 32'(eng_mask), 32'h8);
        wr(4'hF, 8'hF5);
        check(eng_mask == 4'b0101, "R6 load all", 32'(eng_mask), 32'h5);
    endtask

    task automatic t_mode;
        wr(4'hB, 8'h55);
        check(eng_mode[1*8 +: 8] == 8'h55, "R7 mode ch1",
              32'(eng_mode[15:8]), 32'h55);
        check(eng_autoinit == 4'b0010, "R7 autoinit", 32'(eng_autoinit), 2);
        wr(4'hB, 8'hCB);
        check(eng_mode[3*8 +: 8] == 8'hCB && eng_autoinit == 4'b0010,
              "R7 cascade ch3", 32'(eng_mode[31:24]), 32'hCB);
    endtask

    task automatic t_cmd;
        wr(4'h8, 8'h24);
        check(eng_cmd == 8'h24, "R8 cmd", 32'(eng_cmd), 32'h24);
    endtask

    task automatic t_sreq;
        logic [7:0] d;
        wr(4'h9, 8'h05);
        check(eng_sreq == 4'b0010, "R10 set", 32'(eng_sreq), 2);
        rd(4'h8, d);
        check(d[7:4] == 4'b0010, "R10 pending", 32'(d), 32'h20);
        wr(4'h9, 8'h01);
        check(eng_sreq == 0, "R10 clear", 32'(eng_sreq), 0);
    endtask

    task automatic t_status;
        logic [7:0] d;
        @(negedge clk); eng_tc = 4'b0100; eng_hreq = 4'b1000;
        @(negedge clk); eng_tc = 0;
        rd(4'h8, d);
        check(d == 8'h84, "R9 status", 32'(d), 32'h84);
        rd(4'h8, d);
        check(d == 8'h80, "R9 clear on read", 32'(d), 32'h80);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_off = 4'h8; eng_tc = 4'b0001;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0; eng_tc = 0; eng_hreq = 0;
        rd(4'h8, d);
        check(d == 8'h01, "R9 same-cycle pulse", 32'(d), 32'h01);
    endtask

    task automatic t_temp;
        logic [7:0] d;
        @(negedge clk); eng_temp_we = 1; eng_temp_data = 8'h5A;
        @(negedge clk); eng_temp_we = 0;
        rd(4'hD, d);
        check(d == 8'h5A, "R12 temp", 32'(d), 32'h5A);
    endtask

    task automatic t_wb;
        logic [7:0] lo, hi;
        logic [15:0] base;
        base = eng_base_addr[3*WW +: WW];
        @(negedge clk);
        eng_wb_we = 4'b1000;
        eng_wb_addr[3*WW +: WW] = 16'hCAFE;
        eng_wb_cnt[3*WW +: WW] = 16'hFFFF;
        @(negedge clk); eng_wb_we = 0;
        check(eng_base_addr[3*WW +: WW] == base, "R13 base kept",
              32'(eng_base_addr[3*WW +: WW]), 32'(base));
        wr(4'hC, 0);
        rd(4'h7, lo); rd(4'h7, hi);
        check({hi, lo} == 16'hFFFF, "R13 count done", {16'h0, hi, lo}, 32'hFFFF);
        rd(4'h6, lo); rd(4'h6, hi);
        check({hi, lo} == 16'hCAFE, "R13 cur addr", {16'h0, hi, lo}, 32'hCAFE);
        // collision: host writes low byte of ch0 address while engine writes back
        @(negedge clk);
        eng_wb_we = 4'b0001; eng_wb_addr[15:0] = 16'h3344;
        bus_cs = 1; bus_wr = 1; bus_off = 4'h0; bus_wdata = 8'h99;
        @(negedge clk);
        eng_wb_we = 0; bus_cs = 0; bus_wr = 0;
        check(eng_cur_addr[15:0] == 16'h3399, "R13 host wins",
              32'(eng_cur_addr[15:0]), 32'h3399);
        wr(4'hC, 0);
    endtask

    task automatic t_mclr;
        logic [7:0] d;
        logic [15:0] a1;
        wr(4'h8, 8'h77); wr(4'hE, 0); wr(4'h9, 8'h06);
        @(negedge clk); eng_temp_we = 1; eng_temp_data = 8'h3C; eng_tc = 4'b0010;
        @(negedge clk); eng_temp_we = 0; eng_tc = 0;
        wr(4'h2, 8'hAB);        // pointer left high
        a1 = eng_base_addr[1*WW +: WW];
        wr(4'hD, 8'h00);
        check(eng_mask == 4'hF && eng_cmd == 0 && eng_sreq == 0, "R11 regs",
              {eng_cmd, eng_sreq, eng_mask}, 32'h00F);
        check(eng_base_addr[1*WW +: WW] == a1 && eng_mode[15:8] == 8'h55,
              "R11 kept", 32'(eng_base_addr[1*WW +: WW]), 32'(a1));
        rd(4'h8, d);
        check(d == 0, "R11 status", 32'(d), 0);
        rd(4'hD, d);
        check(d == 0, "R11 temp", 32'(d), 0);
        rd(4'h2, d);
        check(d == a1[7:0], "R11 ptr low", 32'(d), 32'(a1[7:0]));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_addr();
        t_cnt();
        t_ptr();
        t_mask();
        t_mode();
        t_cmd();
        t_sreq();
        t_status();
        t_temp();
        t_wb();
        t_mclr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule